// File: doc/BRIEF.md
# Real-time clock interrupt aggregator

This block gathers the event pulses produced by the time-keeping logic of a real-time clock and folds them into two CPU interrupt lines. One line serves the periodic ticks (one each second, minute and hour). The other serves the stopwatch expiry and the alarm match. The event pulses are assumed to be in the bus clock domain already.

A small register interface on the bus clock sets the interrupt enables and reads back the pending status. The periodic ticks each have their own enable bit, and a global periodic gate sits on top of them. The stopwatch and alarm sources have no enable bit of their own. They count as armed while the stopwatch is running or the alarm is switched on, and both of those facts arrive as level inputs. Every pending bit is cleared by writing a one to it.

Each interrupt line also has a registered copy that goes to the power manager as a wake request. Either line can therefore bring the system out of a low-power state.

Top module: `rtc_irq_combiner`

## Requirements
- R1: A tick pulse (bit 0 second, bit 1 minute, bit 2 hour) sets its periodic pending bit at the next clock edge, whatever the enables hold. The pending bits read back at address 1, bits 2:0.
- R2: Writing address 1 clears every pending bit whose data bit is 1, from the next cycle on. Pending bits written with 0 keep their value.
- R3: When a tick and a write-one clear of the same pending bit fall in the same cycle, the bit is set after that edge.
- R4: `irq_periodic_o` is high exactly when control bit 7 (global gate) is 1 and at least one periodic pending bit has its enable bit (control bits 2:0, same order as the pending bits) set.
- R5: With control bit 7 at 0, `irq_periodic_o` stays low whatever the pending and per-source enable bits are.
- R6: `irq_event_o` is high exactly when the stopwatch pending bit is set while `sw_running_i` is 1, or the alarm pending bit is set while `alarm_on_i` is 1.
- R7: A stopwatch expiry sets pending bit 0 at address 2 and an alarm match sets bit 1. Either is set whatever the arming inputs hold, and is cleared by writing 1 to it at address 2. A clear in the same cycle as the event leaves the bit set.
- R8: `wake_periodic_o` and `wake_event_o` equal the value that `irq_periodic_o` and `irq_event_o` held one cycle earlier.
- R9: Reset (active low, asynchronous) clears the control register, all pending bits and both wake outputs.
- R10: A write to address 0 stores all 8 data bits into the control register, and address 0 reads them back. Address 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address (0 control, 1 periodic pending, 2 stopwatch/alarm pending) |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| tick_sec_i | input | 1 | One-cycle pulse each second |
| tick_min_i | input | 1 | One-cycle pulse each minute |
| tick_hour_i | input | 1 | One-cycle pulse each hour |
| sw_expire_i | input | 1 | Stopwatch expiry pulse |
| alarm_match_i | input | 1 | Alarm match pulse |
| sw_running_i | input | 1 | Stopwatch is counting (arms its interrupt) |
| alarm_on_i | input | 1 | Alarm is switched on (arms its interrupt) |
| irq_periodic_o | output | 1 | Periodic CPU interrupt |
| irq_event_o | output | 1 | Stopwatch/alarm CPU interrupt |
| wake_periodic_o | output | 1 | Registered wake request from the periodic line |
| wake_event_o | output | 1 | Registered wake request from the stopwatch/alarm line |

## Verification
The directed part of the run sets a tick while every enable is off, to show that pending bits ignore the enables. It writes zeros and then ones to a pending bit, to tell write-one clearing apart from plain writing. It lands an event and a clear in the same cycle, to tell set priority from clear priority. It then toggles the global gate and the arming inputs on their own, to show which term blocks each line. After that, a long random run mixes ticks, expiries, writes and arming levels. A reference model compares every readable register, both interrupt lines and both wake outputs on every cycle. A reset in the middle of the run shows that all state returns to zero.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int NUM_PER    = 3;
  localparam int NUM_EVT    = 2;
  localparam int GLOBAL_BIT = DATA_W - 1;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_PSTAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_ESTAT = 2'd2;

  // periodic line: any enabled pending source, behind the global gate
  function automatic logic periodic_line(input logic [NUM_PER-1:0] pend,
                                         input logic [NUM_PER-1:0] en,
                                         input logic gate);
    return gate & (|(pend & en));
  endfunction

  // event line: each pending bit counts only while its function is armed
  function automatic logic event_line(input logic sw_pend, input logic sw_run,
                                      input logic al_pend, input logic al_on);
    return (sw_pend & sw_run) | (al_pend & al_on);
  endfunction

  // next state of a pending bit: a new event beats a clear
  function automatic logic pend_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rtc_irq_pend_bank.sv
`timescale 1ns/1ps
module rtc_irq_pend_bank #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  import rtc_irq_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[i] <= 1'b0;
      else        pend_o[i] <= pend_next(pend_o[i], set_i[i], clr_i[i]);
    end

    // R1 / R3 / R7: an event always leaves the bit set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> pend_o[i]);
    // R2: a one without a competing event clears
    a_r2_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
    // R2: a pending bit without a clear holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/rtc_irq_ctrl_reg.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ctrl_o <= '0;
    else if (we_i) ctrl_o <= wdata_i;
  end

  // R10: stored value follows the last write
  a_r10_store: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ctrl_o == $past(wdata_i)));
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(ctrl_o));
endmodule

// File: rtl/rtc_irq_combine.sv
`timescale 1ns/1ps
module rtc_irq_combine #(
  parameter int NUM_PER = 3
) (
  input  logic [NUM_PER-1:0] per_pend_i,
  input  logic [NUM_PER-1:0] per_en_i,
  input  logic               gate_i,
  input  logic               sw_pend_i,
  input  logic               sw_run_i,
  input  logic               al_pend_i,
  input  logic               al_on_i,
  output logic               irq_per_o,
  output logic               irq_evt_o
);
  import rtc_irq_pkg::*;
  always_comb begin
    irq_per_o = periodic_line(per_pend_i, per_en_i, gate_i);
    irq_evt_o = event_line(sw_pend_i, sw_run_i, al_pend_i, al_on_i);
  end
endmodule

// File: rtl/rtc_irq_combiner.sv
`timescale 1ns/1ps
module rtc_irq_combiner
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              tick_sec_i,
  input  logic              tick_min_i,
  input  logic              tick_hour_i,
  input  logic              sw_expire_i,
  input  logic              alarm_match_i,
  input  logic              sw_running_i,
  input  logic              alarm_on_i,
  output logic              irq_periodic_o,
  output logic              irq_event_o,
  output logic              wake_periodic_o,
  output logic              wake_event_o
);
  // named internal events
  logic               wr_ctrl, wr_pclr, wr_eclr;
  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_PER-1:0] per_en, per_set, per_clr, per_pend;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_pend;
  logic               glb_en;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);
  assign wr_pclr = wr_en_i && (wr_addr_i == ADR_PSTAT);
  assign wr_eclr = wr_en_i && (wr_addr_i == ADR_ESTAT);

  assign per_set = {tick_hour_i, tick_min_i, tick_sec_i};
  assign evt_set = {alarm_match_i, sw_expire_i};
  assign per_clr = wr_pclr ? wr_data_i[NUM_PER-1:0] : '0;
  assign evt_clr = wr_eclr ? wr_data_i[NUM_EVT-1:0] : '0;
  assign per_en  = ctrl_q[NUM_PER-1:0];
  assign glb_en  = ctrl_q[GLOBAL_BIT];

  rtc_irq_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(wr_ctrl), .wdata_i(wr_data_i), .ctrl_o(ctrl_q));

  rtc_irq_pend_bank #(.WIDTH(NUM_PER)) u_per (
    .clk(clk), .rst_n(rst_n), .set_i(per_set), .clr_i(per_clr), .pend_o(per_pend));

  rtc_irq_pend_bank #(.WIDTH(NUM_EVT)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(evt_clr), .pend_o(evt_pend));

  rtc_irq_combine #(.NUM_PER(NUM_PER)) u_comb (
    .per_pend_i(per_pend), .per_en_i(per_en), .gate_i(glb_en),
    .sw_pend_i(evt_pend[0]), .sw_run_i(sw_running_i),
    .al_pend_i(evt_pend[1]), .al_on_i(alarm_on_i),
    .irq_per_o(irq_periodic_o), .irq_evt_o(irq_event_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_periodic_o <= 1'b0;
      wake_event_o    <= 1'b0;
    end else begin
      wake_periodic_o <= irq_periodic_o;
      wake_event_o    <= irq_event_o;
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      ADR_CTRL:  rd_data_o = ctrl_q;
      ADR_PSTAT: rd_data_o[NUM_PER-1:0] = per_pend;
      ADR_ESTAT: rd_data_o[NUM_EVT-1:0] = evt_pend;
      default:   rd_data_o = '0;
    endcase
  end

  // R5: no periodic interrupt while the gate is shut
  a_r5_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_periodic_o);
  // R4: a periodic interrupt needs an enabled pending source
  a_r4_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_periodic_o |-> (|(per_pend & per_en)));
  // R6: the event line needs an armed function
  a_r6_needs_arming: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event_o |-> (sw_running_i || alarm_on_i));
  // R8: wake requests trail the interrupt lines by one cycle
  a_r8_wake_per: assert property (@(posedge clk) disable iff (!rst_n)
    irq_periodic_o |=> wake_periodic_o);
  a_r8_wake_evt: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_event_o |=> !wake_event_o);
endmodule

// File: tb/tb_rtc_irq_combiner.sv
`timescale 1ns/1ps
module tb_rtc_irq_combiner;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [4:0] ev = '0;
  logic sw_run = 1'b0, al_on = 1'b0;
  logic irq_p, irq_e, wake_p, wake_e;

  int n_chk = 0, n_fail = 0;
  int m_ctrl = 0, m_pst = 0, m_est = 0, m_wp = 0, m_we = 0;
  int rd0 = 0, rd1 = 0, rd2 = 0, rd3 = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_irq_combiner dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .tick_sec_i(ev[0]), .tick_min_i(ev[1]), .tick_hour_i(ev[2]),
    .sw_expire_i(ev[3]), .alarm_match_i(ev[4]),
    .sw_running_i(sw_run), .alarm_on_i(al_on),
    .irq_periodic_o(irq_p), .irq_event_o(irq_e),
    .wake_periodic_o(wake_p), .wake_event_o(wake_e));

  function automatic int exp_per();
    return ((m_ctrl & 8'h80) != 0 && (m_pst & m_ctrl & 7) != 0) ? 1 : 0;
  endfunction
  function automatic int exp_evt();
    return (((m_est & 1) != 0 && sw_run) || ((m_est & 2) != 0 && al_on)) ? 1 : 0;
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_pst = 0; m_est = 0; m_wp = 0; m_we = 0;
    end else begin
      m_wp = exp_per();
      m_we = exp_evt();
      if (wr_en && wr_addr == 0) m_ctrl = wr_data;
      if (wr_en && wr_addr == 1) m_pst = m_pst & ~int'(wr_data);
      if (wr_en && wr_addr == 2) m_est = m_est & ~int'(wr_data);
      m_pst = (m_pst | int'(ev[2:0])) & 7;
      m_est = (m_est | int'(ev[4:3])) & 3;
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      rd_addr = 2'd0; #0.1 rd0 = rd_data; chk(rd0, m_ctrl, "R10 ctrl readback");
      rd_addr = 2'd1; #0.1 rd1 = rd_data; chk(rd1, m_pst, "R1 periodic pending");
      rd_addr = 2'd2; #0.1 rd2 = rd_data; chk(rd2, m_est, "R7 event pending");
      rd_addr = 2'd3; #0.1 rd3 = rd_data; chk(rd3, 0, "R10 spare address");
      chk(int'(irq_p), exp_per(), "R4 periodic line");
      chk(int'(irq_e), exp_evt(), "R6 event line");
      chk(int'(wake_p), m_wp, "R8 periodic wake");
      chk(int'(wake_e), m_we, "R8 event wake");
    end
  end

  task automatic drive(input bit we, input int a, input int d, input int e);
    @(posedge clk); #1;
    wr_en = we; wr_addr = 2'(a); wr_data = 8'(d); ev = 5'(e);
  endtask
  task automatic idle(); drive(0, 0, 0, 0); endtask
  task automatic settle(); @(negedge clk); #1; endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(); settle();
    chk(rd0 | rd1 | rd2, 0, "R9 registers clear after reset");
    chk(int'(irq_p | irq_e | wake_p | wake_e), 0, "R9 outputs low after reset");

    // R1: tick with all enables off
    drive(0, 0, 0, 5'b00001); idle(); settle();
    chk(rd1, 1, "R1 tick sets pending with enables off");
    chk(int'(irq_p), 0, "R4 no irq without enables");
    // R2: zero write keeps, one write clears
    drive(1, 1, 8'h00, 0); idle(); settle();
    chk(rd1, 1, "R2 zero write keeps pending");
    drive(1, 1, 8'h01, 0); idle(); settle();
    chk(rd1, 0, "R2 one write clears pending");
    // R3: tick and clear together
    drive(1, 1, 8'h02, 5'b00010); idle(); settle();
    chk(rd1, 2, "R3 event beats clear");
    // R5 then R4
    drive(1, 0, 8'h02, 0); idle(); settle();
    chk(int'(irq_p), 0, "R5 gate shut blocks line");
    drive(1, 0, 8'h82, 0); idle(); settle();
    chk(int'(irq_p), 1, "R4 gate open with enabled pending");
    settle();
    chk(int'(wake_p), 1, "R8 wake follows periodic line");
    drive(1, 0, 8'h81, 0); idle(); settle();
    chk(int'(irq_p), 0, "R4 pending source not enabled");
    drive(1, 1, 8'h07, 0); idle();
    // R6 / R7 stopwatch
    drive(0, 0, 0, 5'b01000); idle(); settle();
    chk(rd2, 1, "R7 expiry sets pending while disarmed");
    chk(int'(irq_e), 0, "R6 disarmed stopwatch no irq");
    sw_run = 1'b1; settle();
    chk(int'(irq_e), 1, "R6 running stopwatch raises irq");
    drive(1, 2, 8'h01, 0); idle(); settle();
    chk(int'(irq_e), 0, "R7 stopwatch clear drops irq");
    sw_run = 1'b0;
    // alarm, with clear in same cycle
    drive(1, 2, 8'h02, 5'b10000); idle(); settle();
    chk(rd2, 2, "R7 alarm event beats clear");
    al_on = 1'b1; settle();
    chk(int'(irq_e), 1, "R6 armed alarm raises irq");
    drive(1, 0, 8'h5A, 0); idle(); settle();
    chk(rd0, 8'h5A, "R10 all control bits stored");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      sw_run = 1'($urandom_range(0, 1));
      al_on  = 1'($urandom_range(0, 1));
      drive(($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 255)),
            int'($urandom_range(0, 31)) & int'($urandom_range(0, 31)));
    end
    idle();

    // R9 mid-run reset
    drive(1, 0, 8'hFF, 5'b11111); idle();
    @(posedge clk); #1 rst_n = 1'b0;
    #0.5;
    chk(int'(wake_p | wake_e | irq_p | irq_e), 0, "R9 async reset clears outputs");
    @(posedge clk); #1 rst_n = 1'b1;
    settle();
    chk(rd0 | rd1 | rd2, 0, "R9 registers clear after mid-run reset");
    repeat (3) idle();
    settle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule